// File: doc/BRIEF.md
# Scalar Pipeline Interlock Unit

This block decides when the next scalar operation must be held at issue because one of its source registers is still waiting for an earlier producer. It serves a seven-stage in-order scalar pipeline that runs next to a deep vector pipeline. Each producer class delivers its scalar result at a fixed stage, and forwarding is limited. The unit has one countdown per scalar register. Accepting a producer loads that producer's result stage into the countdown for its destination, and every later clock lowers it by one.

The op waiting at issue presents up to `NSRC` source registers, each tagged with the stage at which it is read. An execute-stage operand is read in stage 4 and an address operand in stage 1. The unit outputs the number of stall cycles still needed and a stall flag. A producer is accepted only in a cycle with no stall, so the op that is being held cannot record itself early. Scalar results that come from the vector pipe arrive at stage 12 and have no fast path into the scalar reads.

Top module: `scalar_interlock`

## Requirements
- R1: After reset no register is pending: any set of valid sources gives `stall_len` 0 and `stall` low.
- R2: Class codes 0 (integer ALU) and 1 (boolean) have result stage 4. A consumer issued right after reads it with no stall at stage 4, and stalls 3 cycles when it reads the value as an address at stage 1.
- R3: Class code 2 (scalar load) has result stage 5. A stage-4 consumer issued right after stalls 1 cycle.
- R4: Class code 3 (32-bit multiply) has result stage 6 and no forward to stage 4 or 5. A following stage-4 consumer stalls 2 cycles and a following stage-1 address consumer stalls 5.
- R5: Class code 4 (special-register move) commits at stage 6. A following stage-4 consumer stalls 2 cycles.
- R6: Class code 5 (scalar result from the vector pipe) has result stage 12 and no bypass. A following stage-4 consumer stalls 8 cycles and a stage-1 consumer stalls 11.
- R7: `stall_len` equals the maximum over valid sources of max(0, P − R + 1 − k). P is the producer's result stage, R is the read stage (1 when `src_addr` is set, else 4), and k is the number of cycles since the producer was accepted. Sources with `src_valid` low do not contribute.
- R8: `stall` is high exactly when `stall_len` is nonzero. While a stalled op holds its sources steady, `stall_len` drops by one each cycle.
- R9: An issue presented while `stall` is high is ignored and creates no pending entry.
- R10: Class codes 6 and 7 create no pending entry.
- R11: A newer accepted producer to a register replaces the older pending entry for that register.
- R12: Register index 0 is tracked like every other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | A producer offers to issue this cycle |
| iss_dst | input | IDXW | Destination scalar register of the producer |
| iss_class | input | 3 | Producer class code (0..7, see R2–R6, R10) |
| src_valid | input | NSRC | Per-source valid of the op waiting at issue |
| src_idx | input | NSRC*IDXW | Source register indices, source s at bits [s*IDXW +: IDXW] |
| src_addr | input | NSRC | 1 = source read at stage 1 (address), 0 = stage 4 |
| stall | output | 1 | Hold the waiting op this cycle |
| stall_len | output | 4 | Remaining stall cycles for the waiting op |

## Verification
The bench aims at the boundaries between the result stages. A load read one cycle too late or too early shows up as a 0 or 2 in place of 1, and a design that forwards the multiply or vector result shows a short stall. It also combines an address-read source with a stage-4 source that targets an older entry. A design that sums the per-source waits instead of taking the maximum, or that counts an invalid source, reports the wrong length. It also offers an issue during a stall, overwrites a pending vector entry with an ALU result, and issues to register 0. A design that lets a held producer through, keeps the stale longer wait, or hardwires register 0 then stalls a later reader wrongly.

// File: rtl/scalar_ilk_pkg.sv
// Shared types and constants for the scalar interlock unit.
// Assumes results never land later than stage 15 (CNT_W = 4).
package scalar_ilk_pkg;

    localparam int CNT_W = 4;

    localparam logic [CNT_W-1:0] RD_STAGE_EXEC = CNT_W'(4);
    localparam logic [CNT_W-1:0] RD_STAGE_ADDR = CNT_W'(1);

    typedef enum logic [2:0] {
        PC_ALU  = 3'd0,
        PC_BOOL = 3'd1,
        PC_LOAD = 3'd2,
        PC_MUL  = 3'd3,
        PC_SPEC = 3'd4,
        PC_VEC  = 3'd5,
        PC_RSV6 = 3'd6,
        PC_RSV7 = 3'd7
    } prod_class_e;

    // Stage at which a producer class makes its scalar result readable; 0 = no result.
    function automatic logic [CNT_W-1:0] result_stage(input prod_class_e c);
        case (c)
            PC_ALU, PC_BOOL: return CNT_W'(4);
            PC_LOAD:         return CNT_W'(5);
            PC_MUL, PC_SPEC: return CNT_W'(6);
            PC_VEC:          return CNT_W'(12);
            default:         return '0;
        endcase
    endfunction

endpackage

// File: rtl/ilk_pending_table.sv
// Per-register countdown of the pending scalar result.
// Each write loads the producer's result stage; the entry then lowers by one
// per clock until it reaches zero, so at k cycles after the write it holds P-k+1.
// Assumes at most one write per cycle.
module ilk_pending_table
    import scalar_ilk_pkg::*;
#(
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] rem [NREG]
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Load on a write to this register, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rem[r] <= '0;
            end else if (wr_en && (wr_idx == IDXW'(r))) begin
                rem[r] <= wr_val;
            end else if (rem[r] != '0) begin
                rem[r] <= rem[r] - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/ilk_src_check.sv
// Stall needed by one source operand: countdown of its register minus the
// source's read stage, floored at zero; zero when the source is not valid.
module ilk_src_check
    import scalar_ilk_pkg::*;
#(
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic             valid,
    input  logic [IDXW-1:0]  idx,
    input  logic             addr_read,
    input  logic [CNT_W-1:0] rem [NREG],
    output logic [CNT_W-1:0] need
);

    logic [CNT_W-1:0] sel;
    logic [CNT_W-1:0] rd;

    // Pick the countdown and read stage, then form the floored difference.
    always_comb begin
        sel  = rem[idx];
        rd   = addr_read ? RD_STAGE_ADDR : RD_STAGE_EXEC;
        need = (valid && (sel > rd)) ? (sel - rd) : '0;
    end

endmodule

// File: rtl/scalar_interlock.sv
// Scalar register interlock: holds the op at issue until every source can be
// read at its read stage, using fixed per-class result stages.
// Assumes in-order issue, at most one scalar producer per cycle, and that the
// caller presents a producer's destination in the same cycle as its sources.
module scalar_interlock
    import scalar_ilk_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NSRC = 3,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [IDXW-1:0]      iss_dst,
    input  logic [2:0]           iss_class,
    input  logic [NSRC-1:0]      src_valid,
    input  logic [NSRC*IDXW-1:0] src_idx,
    input  logic [NSRC-1:0]      src_addr,
    output logic                 stall,
    output logic [CNT_W-1:0]     stall_len
);

    logic [CNT_W-1:0] rem  [NREG];
    logic [CNT_W-1:0] need [NSRC];
    logic [CNT_W-1:0] res_stage;
    logic             accept;

    // Result stage of the offered producer and whether it is recorded.
    always_comb begin
        res_stage = result_stage(prod_class_e'(iss_class));
        accept    = iss_valid && !stall && (res_stage != '0);
    end

    ilk_pending_table #(.NREG(NREG)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept),
        .wr_idx (iss_dst),
        .wr_val (res_stage),
        .rem    (rem)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        ilk_src_check #(.NREG(NREG)) u_src (
            .valid     (src_valid[s]),
            .idx       (src_idx[s*IDXW +: IDXW]),
            .addr_read (src_addr[s]),
            .rem       (rem),
            .need      (need[s])
        );
    end

    // Worst source sets the stall length.
    always_comb begin
        stall_len = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (need[s] > stall_len) stall_len = need[s];
        end
        stall = (stall_len != '0);
    end

endmodule

// File: rtl/scalar_interlock_checker.sv
// Temporal properties of the interlock, observed at the top-level ports.
module scalar_interlock_checker #(
    parameter int NSRC  = 3,
    parameter int IDXW  = 4,
    parameter int CNT_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_valid,
    input logic [IDXW-1:0]      iss_dst,
    input logic [2:0]           iss_class,
    input logic [NSRC-1:0]      src_valid,
    input logic [NSRC*IDXW-1:0] src_idx,
    input logic [NSRC-1:0]      src_addr,
    input logic                 stall,
    input logic [CNT_W-1:0]     stall_len
);

    AST_HOLD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stall) && $stable(src_valid) && $stable(src_idx) && $stable(src_addr)
        |-> stall_len == CNT_W'($past(stall_len) - CNT_W'(1))); // R8

    AST_NO_SOURCE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid == '0) |-> (stall_len == '0)); // R7

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall_len <= CNT_W'(11)); // R7

    AST_VEC_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !stall && iss_class == 3'd5)
        |=> !(src_valid[0] && src_idx[IDXW-1:0] == $past(iss_dst))
            || (stall_len >= (src_addr[0] ? CNT_W'(11) : CNT_W'(8)))); // R6

    AST_MUL_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !stall && iss_class == 3'd3)
        |=> !(src_valid[0] && src_idx[IDXW-1:0] == $past(iss_dst))
            || (stall_len >= (src_addr[0] ? CNT_W'(5) : CNT_W'(2)))); // R4

endmodule

bind scalar_interlock scalar_interlock_checker #(
    .NSRC  (NSRC),
    .IDXW  (IDXW),
    .CNT_W (scalar_ilk_pkg::CNT_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .iss_class (iss_class),
    .src_valid (src_valid),
    .src_idx   (src_idx),
    .src_addr  (src_addr),
    .stall     (stall),
    .stall_len (stall_len)
);

// File: tb/scalar_interlock_test.sv
// Bench: directed corners plus seeded random traffic, checked against a
// model that keeps issue cycle and result stage per register.
module scalar_interlock_test;
    localparam int NREG = 16;
    localparam int NSRC = 3;
    localparam int IDXW = $clog2(NREG);

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 iss_valid;
    logic [IDXW-1:0]      iss_dst;
    logic [2:0]           iss_class;
    logic [NSRC-1:0]      src_valid;
    logic [NSRC*IDXW-1:0] src_idx;
    logic [NSRC-1:0]      src_addr;
    logic                 stall;
    logic [3:0]           stall_len;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t_iss [NREG];
    int p_stg [NREG];

    always #5 clk = ~clk;

    scalar_interlock #(.NREG(NREG), .NSRC(NSRC)) uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
        .iss_class(iss_class), .src_valid(src_valid), .src_idx(src_idx),
        .src_addr(src_addr), .stall(stall), .stall_len(stall_len)
    );

    // Result stage per class code, from R2-R6 and R10.
    function automatic int exp_stage(input int cls);
        case (cls)
            0, 1:    return 4;
            2:       return 5;
            3, 4:    return 6;
            5:       return 12;
            default: return 0;
        endcase
    endfunction

    // Expected stall from R7.
    function automatic int exp_need(input bit [2:0] sv, input int ids [3], input bit [2:0] sa);
        int best = 0;
        for (int s = 0; s < 3; s++) begin
            if (sv[s] && p_stg[ids[s]] != 0) begin
                int v = p_stg[ids[s]] - (sa[s] ? 1 : 4) + 1 - (cyc - t_iss[ids[s]]);
                if (v > best) best = v;
            end
        end
        return best;
    endfunction

    // Drive one cycle, check outputs, advance the model.
    task automatic step(input bit iv, input int dst, input int cls, input bit [2:0] sv,
                        input int i0, input int i1, input int i2, input bit [2:0] sa,
                        input string tag, input int want);
        int ids [3];
        int m;
        int e;
        ids[0] = i0; ids[1] = i1; ids[2] = i2;
        @(negedge clk);
        iss_valid = iv;
        iss_dst   = IDXW'(dst);
        iss_class = 3'(cls);
        src_valid = sv;
        src_idx   = {IDXW'(i2), IDXW'(i1), IDXW'(i0)};
        src_addr  = sa;
        #1;
        m = exp_need(sv, ids, sa);
        e = (want >= 0) ? want : m;
        checks++;
        if (int'(stall_len) != e || stall != (e != 0)) begin
            errors++;
            $display("FAIL %s cyc %0d: stall_len %0d stall %0b, expected %0d", tag, cyc,
                     stall_len, stall, e);
        end
        if (iv && m == 0 && exp_stage(cls) != 0) begin
            t_iss[dst] = cyc;
            p_stg[dst] = exp_stage(cls);
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 3'b000, 0, 0, 0, 3'b000, "R7 idle", 0);
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < NREG; r++) begin
            t_iss[r] = 0;
            p_stg[r] = 0;
        end
        rst_n = 1'b0;
        iss_valid = 0; iss_dst = '0; iss_class = '0;
        src_valid = '0; src_idx = '0; src_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing pending after reset
        step(0, 0, 0, 3'b111, 0, 1, 2, 3'b010, "R1", 0);
        // R2: ALU forwards at stage 4; address read waits 3
        step(1, 1, 0, 3'b000, 0, 0, 0, 3'b000, "R2", 0);
        step(0, 0, 0, 3'b001, 1, 0, 0, 3'b000, "R2", 0);
        idle(13);
        step(1, 2, 1, 3'b000, 0, 0, 0, 3'b000, "R2", 0);
        step(0, 0, 0, 3'b001, 2, 0, 0, 3'b001, "R2", 3);
        idle(13);
        // R3: load-use bubble, then release (R8)
        step(1, 3, 2, 3'b000, 0, 0, 0, 3'b000, "R3", 0);
        step(0, 0, 0, 3'b001, 3, 0, 0, 3'b000, "R3", 1);
        step(0, 0, 0, 3'b001, 3, 0, 0, 3'b000, "R8", 0);
        idle(13);
        // R4: multiply, stage-4 and stage-1 consumers
        step(1, 4, 3, 3'b000, 0, 0, 0, 3'b000, "R4", 0);
        step(0, 0, 0, 3'b010, 0, 4, 0, 3'b000, "R4", 2);
        step(0, 0, 0, 3'b010, 0, 4, 0, 3'b000, "R8", 1);
        step(0, 0, 0, 3'b010, 0, 4, 0, 3'b000, "R8", 0);
        idle(13);
        step(1, 4, 3, 3'b000, 0, 0, 0, 3'b000, "R4", 0);
        step(0, 0, 0, 3'b100, 0, 0, 4, 3'b100, "R4", 5);
        idle(13);
        // R5: special-register move
        step(1, 5, 4, 3'b000, 0, 0, 0, 3'b000, "R5", 0);
        step(0, 0, 0, 3'b001, 5, 0, 0, 3'b000, "R5", 2);
        idle(13);
        // R6: vector-pipe scalar result
        step(1, 6, 5, 3'b000, 0, 0, 0, 3'b000, "R6", 0);
        step(0, 0, 0, 3'b001, 6, 0, 0, 3'b000, "R6", 8);
        idle(13);
        step(1, 6, 5, 3'b000, 0, 0, 0, 3'b000, "R6", 0);
        step(0, 0, 0, 3'b001, 6, 0, 0, 3'b001, "R6", 11);
        idle(13);
        // R7: maximum over sources, invalid source ignored
        step(1, 1, 2, 3'b000, 0, 0, 0, 3'b000, "R7", 0);
        step(1, 2, 3, 3'b000, 0, 0, 0, 3'b000, "R7", 0);
        step(0, 0, 0, 3'b011, 1, 2, 2, 3'b110, "R7", 5);
        idle(13);
        // R9: issue offered during a stall is dropped
        step(1, 7, 5, 3'b000, 0, 0, 0, 3'b000, "R9", 0);
        step(1, 8, 5, 3'b001, 7, 0, 0, 3'b000, "R9", 8);
        idle(13);
        step(0, 0, 0, 3'b001, 8, 0, 0, 3'b001, "R9", 0);
        // R10: reserved classes record nothing
        step(1, 9, 6, 3'b000, 0, 0, 0, 3'b000, "R10", 0);
        step(1, 10, 7, 3'b001, 9, 0, 0, 3'b001, "R10", 0);
        step(0, 0, 0, 3'b001, 10, 0, 0, 3'b001, "R10", 0);
        // R11: newer producer replaces older entry
        step(1, 11, 5, 3'b000, 0, 0, 0, 3'b000, "R11", 0);
        step(1, 11, 0, 3'b000, 0, 0, 0, 3'b000, "R11", 0);
        step(0, 0, 0, 3'b001, 11, 0, 0, 3'b000, "R11", 0);
        idle(13);
        // R12: register 0 is an ordinary register
        step(1, 0, 3, 3'b000, 0, 0, 0, 3'b000, "R12", 0);
        step(0, 0, 0, 3'b001, 0, 0, 0, 3'b000, "R12", 2);
        idle(13);

        // R7: seeded random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            bit iv;
            bit [2:0] sv;
            bit [2:0] sa;
            iv = 1'($urandom % 2);
            sv = 3'($urandom % 8);
            sa = 3'($urandom % 8);
            step(iv, int'($urandom % 4), int'($urandom % 8), sv,
                 int'($urandom % 4), int'($urandom % 4), int'($urandom % NREG), sa,
                 "R7 random", -1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule